// File: doc/BRIEF.md
# Status Flag Set/Clear Controller

This block keeps the eight status flags of a serial controller: a run flag that selects between configuration mode and operational mode, a host-select flag, and six error flags (mode, transmit overflow, receive overflow, abort, transmit underflow, receive underflow). Software never writes a flag value directly. It writes a command word in which every flag owns one set strobe and one clear strobe, so any flag can change without a read-modify-write of the others.

The serial engine reports errors as single-cycle pulses on a six-bit event input. Five of those events are captured only when the matching capture-enable bit in the control word is 1. Mode errors are always captured. The six error flags are combined into one level-sensitive error interrupt. A live busy signal from the engine is passed through into the readable status word. When the run flag is 0, the block drives a configuration-mode output that other logic uses as its configuration lock.

Top module: `sflag_ctrl`

## Requirements
- R1: After reset every flag is 0, status_word reads 0 when busy_in is 0, cfg_mode is 1 and err_irq is 0.
- R2: status_word places the flags as follows: run at bit 0, host select at 1, mode error at 7, transmit overflow at 8, receive overflow at 9, abort at 10, transmit underflow at 11 and receive underflow at 12. busy_in is shown at bit 13 in the same cycle. Every other bit reads 0.
- R3: In a command write (cmd_we=1), cmd_word bit 1 sets the run flag and bit 0 clears it. Bit 3 sets host select and bit 2 clears it. The new value appears in status_word one clock later.
- R4: In a command write, the error flags are set and cleared by these cmd_word bits: receive underflow is set by bit 5 and cleared by bit 4; mode error is set by bit 7 and cleared by bit 6. Transmit overflow, receive overflow, abort and transmit underflow are cleared by bits 8, 9, 10 and 11 and set by bits 12, 13, 14 and 15 respectively.
- R5: When one write carries both the set strobe and the clear strobe of the same flag, the flag ends up set.
- R6: hw_evt bit 0 (mode error) always sets the mode error flag. hw_evt bits 1 to 5 (transmit overflow, receive overflow, abort, transmit underflow, receive underflow) set their flag one clock later when ctrl_word bits 8 to 12 respectively are 1.
- R7: A gated event (hw_evt bits 1 to 5) whose ctrl_word enable bit is 0 leaves its flag unchanged.
- R8: If a hardware event and a software clear of the same flag arrive in the same cycle, the flag ends up set.
- R9: err_irq is 1 exactly when at least one of the six error flags is 1.
- R10: cfg_mode is 1 exactly when the run flag is 0.
- R11: While cmd_we is 0 and no event is present, every flag keeps its value, whatever cmd_word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Qualifies cmd_word for one cycle |
| cmd_word | input | CMD_W (16) | Set and clear strobes, one pair per flag |
| ctrl_word | input | CTRL_W (16) | Control word; bits 8 to 12 enable error capture |
| hw_evt | input | 6 | Single-cycle error events from the serial engine |
| busy_in | input | 1 | Engine busy level, shown at status bit 13 |
| status_word | output | STAT_W (16) | Readable status word |
| err_irq | output | 1 | Error interrupt request |
| cfg_mode | output | 1 | High while the controller is in configuration mode |

## Verification
A flag held in the wrong state appears at the status word one clock after the write or event that caused it. If the flag is an error flag, err_irq shows the same fault in the same cycle, and a wrong run flag is also visible on cfg_mode. The vectors focus on the places where a swapped strobe position, a lost enable gate or a reversed priority would leave a flag off by one bit or with the wrong value. Each of these is observed one cycle later and before the next stimulus. Two cases are placed so that a wrong priority cannot hide behind a flag that was already in its final state: set and clear in the same write, and an event arriving together with a clear.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int NUM_FLAGS = 8;
    localparam int NUM_ERR   = 6;
    localparam int ERR_BASE  = 2;
    localparam int BUSY_POS  = 13;

    localparam int FL_RUN   = 0;
    localparam int FL_HOST  = 1;
    localparam int FL_MODE  = 2;
    localparam int FL_TXOVF = 3;
    localparam int FL_RXOVF = 4;
    localparam int FL_ABORT = 5;
    localparam int FL_TXUND = 6;
    localparam int FL_RXUND = 7;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
    } flag_state_t;

    function automatic int stat_bit(input int f);
        case (f)
            FL_RUN:   return 0;
            FL_HOST:  return 1;
            FL_MODE:  return 7;
            FL_TXOVF: return 8;
            FL_RXOVF: return 9;
            FL_ABORT: return 10;
            FL_TXUND: return 11;
            default:  return 12;
        endcase
    endfunction

    function automatic int set_bit(input int f);
        case (f)
            FL_RUN:   return 1;
            FL_HOST:  return 3;
            FL_MODE:  return 7;
            FL_TXOVF: return 12;
            FL_RXOVF: return 13;
            FL_ABORT: return 14;
            FL_TXUND: return 15;
            default:  return 5;
        endcase
    endfunction

    function automatic int clr_bit(input int f);
        case (f)
            FL_RUN:   return 0;
            FL_HOST:  return 2;
            FL_MODE:  return 6;
            FL_TXOVF: return 8;
            FL_RXOVF: return 9;
            FL_ABORT: return 10;
            FL_TXUND: return 11;
            default:  return 4;
        endcase
    endfunction

    // capture-enable position in the control word, -1 for an ungated flag
    function automatic int gate_bit(input int f);
        case (f)
            FL_TXOVF: return 8;
            FL_RXOVF: return 9;
            FL_ABORT: return 10;
            FL_TXUND: return 11;
            FL_RXUND: return 12;
            default:  return -1;
        endcase
    endfunction

endpackage

// File: rtl/sflag_cmd_decode.sv
module sflag_cmd_decode
    import sflag_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    output flag_vec_t        set_vec,
    output flag_vec_t        clr_vec
);

    logic unused_cmd;
    assign unused_cmd = ^cmd_word;

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        localparam int SB = set_bit(f);
        localparam int CB = clr_bit(f);
        assign set_vec[f] = cmd_we & cmd_word[SB];
        assign clr_vec[f] = cmd_we & cmd_word[CB];
    end

endmodule

// File: rtl/sflag_evt_gate.sv
module sflag_evt_gate
    import sflag_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic [NUM_ERR-1:0] hw_evt,
    output flag_vec_t          hw_set
);

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_word;

    assign hw_set[FL_RUN]  = 1'b0;
    assign hw_set[FL_HOST] = 1'b0;

    for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
        localparam int FL = e + ERR_BASE;
        localparam int GB = gate_bit(FL);
        if (GB < 0) begin : g_open
            assign hw_set[FL] = hw_evt[e];
        end else begin : g_gated
            assign hw_set[FL] = hw_evt[e] & ctrl_word[GB];
        end
    end

endmodule

// File: rtl/sflag_bank.sv
module sflag_bank
    import sflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    input  flag_vec_t hw_set,
    output flag_vec_t flags_q
);

    flag_state_t st_d, st_q;

    // clear first, then set strobes and events override it
    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_vec) | set_vec | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;

endmodule

// File: rtl/sflag_status_pack.sv
module sflag_status_pack
    import sflag_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  flag_vec_t         flags,
    input  logic              busy_in,
    output logic [STAT_W-1:0] status_word,
    output logic              err_irq,
    output logic              cfg_mode
);

    logic [STAT_W-1:0] placed [NUM_FLAGS];

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_place
        localparam int SP = stat_bit(f);
        always_comb begin
            placed[f]     = '0;
            placed[f][SP] = flags[f];
        end
    end

    always_comb begin
        status_word = '0;
        for (int f = 0; f < NUM_FLAGS; f++) begin
            status_word = status_word | placed[f];
        end
        status_word[BUSY_POS] = busy_in;
    end

    assign err_irq  = |flags[NUM_FLAGS-1:ERR_BASE];
    assign cfg_mode = ~flags[FL_RUN];

endmodule

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
    import sflag_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int CTRL_W = 16,
    parameter int STAT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic [NUM_ERR-1:0] hw_evt,
    input  logic               busy_in,
    output logic [STAT_W-1:0]  status_word,
    output logic               err_irq,
    output logic               cfg_mode
);

    flag_vec_t set_vec, clr_vec, hw_set, flags_q;

    sflag_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_word (cmd_word),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec)
    );

    sflag_evt_gate #(.CTRL_W(CTRL_W)) u_gate (
        .ctrl_word (ctrl_word),
        .hw_evt    (hw_evt),
        .hw_set    (hw_set)
    );

    sflag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .hw_set  (hw_set),
        .flags_q (flags_q)
    );

    sflag_status_pack #(.STAT_W(STAT_W)) u_pack (
        .flags       (flags_q),
        .busy_in     (busy_in),
        .status_word (status_word),
        .err_irq     (err_irq),
        .cfg_mode    (cfg_mode)
    );

endmodule

// File: rtl/sflag_ctrl_chk.sv
module sflag_ctrl_chk
    import sflag_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int CTRL_W = 16,
    parameter int STAT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_we,
    input logic [CMD_W-1:0]   cmd_word,
    input logic [CTRL_W-1:0]  ctrl_word,
    input logic [NUM_ERR-1:0] hw_evt,
    input logic               busy_in,
    input logic [STAT_W-1:0]  status_word,
    input logic               err_irq,
    input logic               cfg_mode
);

    logic unused_busy;
    assign unused_busy = busy_in;

    AST_RUN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_word[1]) |=> status_word[0]); // R5
    AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_word[0] && !cmd_word[1]) |=> !status_word[0]); // R3
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_word[8] && !ctrl_word[8] && !(cmd_we && cmd_word[12])) |=> !status_word[8]); // R7
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt[1] && ctrl_word[8]) |=> status_word[8]); // R8
    AST_MODE_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt[0] |=> status_word[7]); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (|status_word[12:7])); // R9
    AST_CFG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode == !status_word[0]); // R10
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && hw_evt == '0) |=> $stable(status_word[12:0])); // R11

endmodule

bind sflag_ctrl sflag_ctrl_chk #(
    .CMD_W  (CMD_W),
    .CTRL_W (CTRL_W),
    .STAT_W (STAT_W)
) u_chk (.*);

// File: tb/sflag_ctrl_test.sv
`timescale 1ns/1ps
module sflag_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [15:0] ctrl_word = '0;
    logic [5:0]  hw_evt = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status_word;
    logic        err_irq;
    logic        cfg_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sflag_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_word    (cmd_word),
        .ctrl_word   (ctrl_word),
        .hw_evt      (hw_evt),
        .busy_in     (busy_in),
        .status_word (status_word),
        .err_irq     (err_irq),
        .cfg_mode    (cfg_mode)
    );

    // {we, cmd[15:0], gate enables for ctrl[12:8], events[5:0], expected status[15:0]}
    localparam int NV = 18;
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 16'h0002, 5'h00, 6'h00, 16'h0001},
        {1'b1, 16'h0008, 5'h00, 6'h00, 16'h0003},
        {1'b1, 16'h0001, 5'h00, 6'h00, 16'h0002},
        {1'b1, 16'hF0A0, 5'h00, 6'h00, 16'h1F82},
        {1'b1, 16'h0F50, 5'h00, 6'h00, 16'h0002},
        {1'b1, 16'h0003, 5'h00, 6'h00, 16'h0003},
        {1'b1, 16'h0004, 5'h00, 6'h00, 16'h0001},
        {1'b1, 16'h000C, 5'h00, 6'h00, 16'h0003},
        {1'b1, 16'h0030, 5'h00, 6'h00, 16'h1003},
        {1'b1, 16'h0010, 5'h00, 6'h00, 16'h0003},
        {1'b0, 16'h0000, 5'h00, 6'h3F, 16'h0083},
        {1'b1, 16'h0040, 5'h00, 6'h00, 16'h0003},
        {1'b0, 16'h0000, 5'h1F, 6'h3E, 16'h1F03},
        {1'b1, 16'h0F10, 5'h1F, 6'h02, 16'h0103},
        {1'b0, 16'hFFFF, 5'h00, 6'h00, 16'h0103},
        {1'b0, 16'h0000, 5'h04, 6'h18, 16'h0503},
        {1'b0, 16'h0000, 5'h00, 6'h00, 16'h0503},
        {1'b1, 16'h0F50, 5'h00, 6'h00, 16'h0003}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 6: return "R3";
            3, 4, 9, 11: return "R4";
            5, 7, 8: return "R5";
            10: return "R6 R7";
            12: return "R6";
            13: return "R8";
            14, 16: return "R11";
            15: return "R7";
            default: return "R4 R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 status", 32'(status_word), 32'h0);
        check("R1 cfg_mode", 32'(cfg_mode), 32'h1);
        check("R1 err_irq", 32'(err_irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", 32'(status_word), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] exp;
            cmd_we    = VEC[i][43];
            cmd_word  = VEC[i][42:27];
            ctrl_word = {3'b000, VEC[i][26:22], 8'hA5};
            hw_evt    = VEC[i][21:16];
            exp       = VEC[i][15:0];
            @(negedge clk);
            cmd_we = 1'b0; cmd_word = '0; hw_evt = '0; ctrl_word = '0;
            check({vec_tag(i), " status"}, 32'(status_word), 32'(exp));
            check("R9 err_irq", 32'(err_irq), 32'(|exp[12:7]));
            check("R10 cfg_mode", 32'(cfg_mode), 32'(!exp[0]));
        end

        // R2: busy passthrough, same cycle
        #1 busy_in = 1'b1;
        #1 check("R2 busy bit", 32'(status_word), 32'h2003);
        busy_in = 1'b0;
        #1 check("R2 busy low", 32'(status_word), 32'h0003);

        // R8: clear and event on receive underflow in the same cycle
        @(negedge clk);
        cmd_we = 1'b1; cmd_word = 16'h0010; ctrl_word = 16'h1000; hw_evt = 6'h20;
        @(negedge clk);
        cmd_we = 1'b0; cmd_word = '0; ctrl_word = '0; hw_evt = '0;
        check("R8 rx underflow kept", 32'(status_word), 32'h1003);
        check("R9 irq set", 32'(err_irq), 32'h1);

        // R1: reset in mid operation
        rst_n = 1'b0;
        #1 check("R1 async reset", 32'(status_word), 32'h0);
        check("R1 cfg after reset", 32'(cfg_mode), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 quiet after reset", 32'(status_word), 32'h0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule